// File: doc/BRIEF.md
# Dual-Mode Converter Sample Capture

This block is the receive side of a 12-bit converter's digital output. It runs entirely on the clock forwarded by the converter and has two ways of taking in a sample, chosen by a static select. In parallel mode it registers twelve data lines and an overrange line on the rising edge of the forwarded clock. In double-data-rate mode the word arrives on six lanes. Each lane carries an even-numbered bit while the clock is rising and the odd bit just above it at the falling edge. The block takes both halves and rebuilds the 12-bit word.

The output is a registered sample, a valid strobe and an overrange flag, all in the forwarded-clock domain. When the select changes, the pipeline is flushed, so no output word ever mixes bits taken under two different modes. Edge sampling is modelled behaviourally: one rising-edge register and one falling-edge register per lane.

Top module: `adc_dual_capture`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `sample_valid` = 0, `sample` = 0 and `sample_ovr` = 0. Reset is synchronous, active low.
- R2: At the first rising edge with `rst_n` high, `sample_valid` goes to 1, provided `ddr_mode` is unchanged since reset. After that it stays 1 for as long as `ddr_mode` is held.
- R3: With `ddr_mode` = 0, `sample` after a rising edge equals the `par_data` sampled at that edge, with bit i from line i.
- R4: With `ddr_mode` = 0, `sample_ovr` after a rising edge equals the `par_ovr` sampled at that edge.
- R5: With `ddr_mode` = 1, bit 2k of the word is `ddr_lane[k]` sampled at a rising edge, and bit 2k+1 is `ddr_lane[k]` sampled at the falling edge that follows. The rebuilt word is presented on `sample` after the next rising edge.
- R6: With `ddr_mode` = 1, `sample_ovr` stays 0 whatever `par_ovr` does.
- R7: If a rising edge sees `ddr_mode` differ from its value at the previous edge, `sample_valid` is 0 after that edge and after the next one. While `sample_valid` is 0, `sample` is 0. The third edge presents a word built wholly in the new mode.
- R8: Inputs of the unselected mode have no effect on the outputs. This means `ddr_lane` in parallel mode, and `par_data` and `par_ovr` in double-data-rate mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fclk | input | 1 | Forwarded clock from the converter |
| rst_n | input | 1 | Synchronous reset, active low |
| ddr_mode | input | 1 | 0 = parallel lines, 1 = double-data-rate lanes |
| par_data | input | 12 | Parallel data lines |
| par_ovr | input | 1 | Parallel overrange line |
| ddr_lane | input | 6 | Double-data-rate lanes; lane k carries bits 2k and 2k+1 |
| sample | output | 12 | Captured sample |
| sample_valid | output | 1 | Sample strobe |
| sample_ovr | output | 1 | Captured overrange flag |

## Verification
A parallel word and its overrange bit are due on the outputs right after the rising edge that samples them. A double-data-rate word is due one rising edge after its even half was taken, with its odd half taken at the falling edge between the two. After a mode change, valid is due low across the next two edges. The bench drives every input half a phase away from the edge that samples it and reads every output at the falling edge after the rising edge that updates it. It keeps each word one cycle so the double-data-rate expectation can use the previous cycle's data, and it counts edges since the last mode change to predict the strobe.

// File: rtl/adc_dual_capture.sv
module adc_dual_capture #(
  parameter int WORD_W = 12
) (
  input  logic              fclk,
  input  logic              rst_n,
  input  logic              ddr_mode,
  input  logic [WORD_W-1:0] par_data,
  input  logic              par_ovr,
  input  logic [WORD_W/2-1:0] ddr_lane,
  output logic [WORD_W-1:0] sample,
  output logic              sample_valid,
  output logic              sample_ovr
);
  localparam int LANES = WORD_W / 2;

  logic [LANES-1:0]  rise_q;
  logic [LANES-1:0]  fall_q;
  logic [WORD_W-1:0] ddr_word;
  logic              mode_q;
  logic              flush_q;
  logic              mode_change;

  always_ff @(posedge fclk) rise_q <= ddr_lane;
  always_ff @(negedge fclk) fall_q <= ddr_lane;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign ddr_word[2*k]   = rise_q[k];
    assign ddr_word[2*k+1] = fall_q[k];
  end

  assign mode_change = ddr_mode != mode_q;

  always_ff @(posedge fclk) begin
    if (!rst_n) begin
      mode_q       <= ddr_mode;
      flush_q      <= 1'b0;
      sample       <= '0;
      sample_valid <= 1'b0;
      sample_ovr   <= 1'b0;
    end else begin
      mode_q  <= ddr_mode;
      flush_q <= mode_change;
      if (mode_change || flush_q) begin
        sample       <= '0;
        sample_valid <= 1'b0;
        sample_ovr   <= 1'b0;
      end else begin
        sample       <= mode_q ? ddr_word : par_data;
        sample_valid <= 1'b1;
        sample_ovr   <= !mode_q && par_ovr;
      end
    end
  end
endmodule

// File: rtl/adc_dual_capture_chk.sv
module adc_dual_capture_chk #(
  parameter int WORD_W = 12
) (
  input logic              fclk,
  input logic              rst_n,
  input logic              ddr_mode,
  input logic [WORD_W-1:0] sample,
  input logic              sample_valid,
  input logic              sample_ovr
);
  p_steady_valid_r2: assert property (@(posedge fclk) disable iff (!rst_n)
    ($stable(ddr_mode) && $past(ddr_mode) == $past(ddr_mode, 2)) |=> sample_valid);

  p_ddr_no_ovr_r6: assert property (@(posedge fclk) disable iff (!rst_n)
    $past(ddr_mode) |-> !sample_ovr);

  p_flush_first_r7: assert property (@(posedge fclk) disable iff (!rst_n)
    (ddr_mode != $past(ddr_mode)) |=> !sample_valid);

  p_flush_second_r7: assert property (@(posedge fclk) disable iff (!rst_n)
    ($past(rst_n) && $past(ddr_mode) != $past(ddr_mode, 2)) |=> !sample_valid);

  p_idle_zero_r7: assert property (@(posedge fclk) disable iff (!rst_n)
    !sample_valid |-> (sample == '0 && !sample_ovr));
endmodule

bind adc_dual_capture adc_dual_capture_chk #(.WORD_W(WORD_W)) u_chk (
  .fclk(fclk),
  .rst_n(rst_n),
  .ddr_mode(ddr_mode),
  .sample(sample),
  .sample_valid(sample_valid),
  .sample_ovr(sample_ovr)
);

// File: tb/adc_dual_capture_tb.sv
module adc_dual_capture_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int L = W / 2;

  logic         fclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ddr_mode = 1'b0;
  logic [W-1:0] par_data = '0;
  logic         par_ovr = 1'b0;
  logic [L-1:0] ddr_lane = '0;
  logic [W-1:0] sample;
  logic         sample_valid;
  logic         sample_ovr;

  int checks = 0;
  int fails = 0;
  int since = 100;
  bit prev_rst = 1'b0;
  bit prev_mode = 1'b0;
  logic [W-1:0] prev_w = '0;

  always #(CLK_PERIOD/2) fclk = ~fclk;

  adc_dual_capture #(.WORD_W(W)) u_dut (
    .fclk(fclk), .rst_n(rst_n), .ddr_mode(ddr_mode), .par_data(par_data),
    .par_ovr(par_ovr), .ddr_lane(ddr_lane), .sample(sample),
    .sample_valid(sample_valid), .sample_ovr(sample_ovr)
  );

  function automatic logic [L-1:0] even_half(input logic [W-1:0] w);
    for (int k = 0; k < L; k++) even_half[k] = w[2*k];
  endfunction

  function automatic logic [L-1:0] odd_half(input logic [W-1:0] w);
    for (int k = 0; k < L; k++) odd_half[k] = w[2*k+1];
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit rst_v, input bit mode_v, input bit dir, input logic [W-1:0] dw, input bit dovr);
    logic [W-1:0] w, junk;
    bit o, chg, ev;
    logic [W-1:0] ed;
    w    = dir ? dw : W'($urandom);
    o    = dir ? dovr : 1'($urandom);
    junk = W'($urandom);
    rst_n    = rst_v;
    ddr_mode = mode_v;
    if (mode_v) begin
      par_data = junk;
      par_ovr  = 1'($urandom);
      ddr_lane = even_half(w);
    end else begin
      par_data = w;
      par_ovr  = o;
      ddr_lane = even_half(junk);
    end
    @(posedge fclk);
    #2;
    ddr_lane = mode_v ? odd_half(w) : odd_half(junk);
    @(negedge fclk);
    #1;
    chg = rst_v && prev_rst && (mode_v != prev_mode);
    if (!rst_v) since = 100;
    else if (chg) since = 0;
    else if (since < 100) since++;
    ev = rst_v && since >= 2;
    ed = !ev ? '0 : (mode_v ? prev_w : w);
    if (!rst_v) begin
      check(!sample_valid && sample == '0 && !sample_ovr, "R1 reset outputs", {sample_valid, sample_ovr, sample[W-3:0]}, '0);
    end else begin
      if (!prev_rst) check(sample_valid == 1'b1, "R2 valid after release", W'(sample_valid), W'(1));
      else if (since < 2) check(sample_valid == 1'b0 && sample == '0, "R7 flush window", {sample_valid, sample[W-2:0]}, '0);
      else check(sample_valid == 1'b1, "R2 valid steady", W'(sample_valid), W'(1));
      if (ev) begin
        if (mode_v) begin
          check(sample == ed, "R5 R8 ddr word", sample, ed);
          check(sample_ovr == 1'b0, "R6 R8 ddr ovr", W'(sample_ovr), W'(0));
        end else begin
          check(sample == ed, "R3 R8 parallel word", sample, ed);
          check(sample_ovr == o, "R4 parallel ovr", W'(sample_ovr), W'(o));
        end
      end
    end
    prev_rst  = rst_v;
    prev_mode = mode_v;
    prev_w    = w;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 1'b0, '0, 1'b0);
    // R3 R4 directed parallel corners
    cycle(1'b1, 1'b0, 1'b1, 12'h000, 1'b0);
    cycle(1'b1, 1'b0, 1'b1, 12'hFFF, 1'b1);
    cycle(1'b1, 1'b0, 1'b1, 12'hA5A, 1'b1);
    for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0, 1'b0, '0, 1'b0);
    // R7 switch to ddr, then R5 even/odd separation corners
    cycle(1'b1, 1'b1, 1'b0, '0, 1'b0);
    cycle(1'b1, 1'b1, 1'b0, '0, 1'b0);
    cycle(1'b1, 1'b1, 1'b1, 12'hAAA, 1'b1);
    cycle(1'b1, 1'b1, 1'b1, 12'h555, 1'b1);
    cycle(1'b1, 1'b1, 1'b1, 12'hFFF, 1'b1);
    cycle(1'b1, 1'b1, 1'b1, 12'h000, 1'b0);
    cycle(1'b1, 1'b1, 1'b1, 12'h801, 1'b1);
    for (int i = 0; i < 40; i++) cycle(1'b1, 1'b1, 1'b0, '0, 1'b0);
    // R7 one-cycle glitch on the select
    cycle(1'b1, 1'b0, 1'b0, '0, 1'b0);
    cycle(1'b1, 1'b1, 1'b0, '0, 1'b0);
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, 1'b0, '0, 1'b0);
    // R1 R2 reset in ddr mode and release
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 1'b0, '0, 1'b0);
    for (int i = 0; i < 10; i++) cycle(1'b1, 1'b1, 1'b0, '0, 1'b0);
    // random mode walk
    for (int i = 0; i < 400; i++) begin
      bit m;
      m = ($urandom % 16 == 0) ? !prev_mode : prev_mode;
      cycle(1'b1, m, 1'b0, '0, 1'b0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule